// File: doc/BRIEF.md
# Microstepping Phase Sequencer

This block produces the excitation pattern for a two-phase unipolar stepper motor. It keeps one position inside a 32-position electrical cycle. On every rising edge of the step clock it moves that position by one increment of the selected resolution, clockwise or counter-clockwise. For each phase it outputs a polarity select and a 4-bit current-ratio code. A downstream current regulator turns the code into a trip level, so analog reference generation is not part of this block.

The four resolutions (full, half, quarter and eighth step) are all strided walks through the same 32-position table. The full-step grid sits on the diagonal positions, where both phases carry the same current. Half step uses the diagonal positions plus the single-phase positions between them. At the diagonals, the two coarse resolutions drive both phases at the full-scale code. The fine resolutions use the 70.7% code there.

A hold input freezes the position and makes the sequencer ignore step edges. An asynchronous reset returns the sequencer to the home position. A monitor output goes high whenever the position is a diagonal, two-phase position.

Top module: `ustep_sequencer`

## Requirements
- R1: While `rst` is high, and at once when it rises (without waiting for a step edge), the position is home (index 0). In that state `ratio_a` = 4'hF, `ratio_b` = 4'h0, `pol_a` = 1, `pol_b` = 1 and `diag_mon` = 0.
- R2: For index i, take quadrant q = i/8 and offset o = i%8. Phase A uses step k = 8-o when q is even and k = o when q is odd. Phase B uses 8-k. Step k maps to code 2k for k < 8, and k = 8 maps to 4'hF. These codes stand for 0, 19.5, 38.2, 55.5, 70.7, 83.1, 92.4, 98.1 and 100 percent.
- R3: `pol_a` is 1 (positive winding) in quadrants 0 and 3 and 0 in quadrants 1 and 2. `pol_b` is 1 in quadrants 0 and 1 and 0 in quadrants 2 and 3.
- R4: With `dir` = 0 an on-grid step adds the stride to the index. With `dir` = 1 it subtracts the stride. The index wraps modulo 32 in both directions.
- R5: `res_sel` selects the resolution and its stride: 2'b00 is full step (stride 8), 2'b10 is half step (stride 4), 2'b01 is quarter step (stride 2) and 2'b11 is eighth step (stride 1).
- R6: The full-step grid is the set of indices with i%8 = 4. The other grids are the multiples of their stride. If the index is off the selected grid, a step moves to the nearest grid point in the stepping direction instead of adding the stride.
- R7: At diagonal positions (o = 4) both codes are 4'hF when the latched resolution is full or half step, and 4'h8 when it is quarter or eighth step.
- R8: Changes on `dir`, `res_sel` and `hold` between step edges leave every output unchanged. They act only at the next rising edge of `step_clk`.
- R9: A rising step edge that finds `hold` high changes neither the position nor the latched resolution, so every output keeps its value.
- R10: `diag_mon` is 1 exactly at the diagonal positions (o = 4) and 0 at every other position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| step_clk | input | 1 | Step clock; each rising edge moves the position |
| rst | input | 1 | Asynchronous reset to the home position, active high |
| hold | input | 1 | Freezes the position and makes the sequencer ignore step edges |
| dir | input | 1 | Stepping direction: 0 clockwise (index up), 1 counter-clockwise |
| res_sel | input | 2 | Step resolution select, encoded as in R5 |
| pol_a | output | 1 | Phase A polarity select |
| pol_b | output | 1 | Phase B polarity select |
| ratio_a | output | 4 | Phase A current-ratio code |
| ratio_b | output | 4 | Phase B current-ratio code |
| diag_mon | output | 1 | High at two-phase (diagonal) positions |

## Verification
The assertions assume three things about the inputs. `dir`, `res_sel` and `hold` are settled before each rising step edge and do not move at that edge. Reset is raised before the first step edge. Every `res_sel` value is one of the four legal codes. The bench changes all inputs on the falling edge of the step clock, so each input has half a period of setup and hold. It raises reset 1 ns into the run, before any rising edge. It draws `res_sel` from the full 2-bit range, so every code is a legal resolution, and it holds each resolution for runs of steps to reach off-grid starting points.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  // Sizing of the electrical cycle.
  localparam int IDX_W  = 5;               // 32 positions per cycle
  localparam int OCT_W  = IDX_W - 2;       // offset bits within a quadrant
  localparam int OCT_N  = 1 << OCT_W;      // positions per quadrant
  localparam int MAG_W  = OCT_W + 1;       // magnitude step 0..OCT_N
  localparam int CODE_W = 4;               // width of a current-ratio code

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MAG_W-1:0]  mag_t;

  typedef enum logic [1:0] {
    RES_FULL    = 2'b00,
    RES_QUARTER = 2'b01,
    RES_HALF    = 2'b10,
    RES_EIGHTH  = 2'b11
  } res_e;

  // log2 of the index stride for a resolution
  function automatic int stride_log2(input res_e r);
    case (r)
      RES_FULL:    return OCT_W;
      RES_HALF:    return OCT_W - 1;
      RES_QUARTER: return OCT_W - 2;
      default:     return 0;
    endcase
  endfunction

  // Full steps sit on the diagonals; the other grids start at zero.
  function automatic idx_t grid_offset(input res_e r);
    return (r == RES_FULL) ? idx_t'(OCT_N / 2) : '0;
  endfunction

  // Coarse resolutions drive the diagonals at full scale.
  function automatic logic is_coarse(input res_e r);
    return (r == RES_FULL) || (r == RES_HALF);
  endfunction

  // Next position: stride when on the grid, otherwise snap to the
  // nearest grid point in the stepping direction. Wraps via width.
  function automatic idx_t next_index(input idx_t cur, input logic ccw,
                                      input res_e r);
    idx_t stride;
    idx_t mask;
    idx_t rem;
    stride = idx_t'(1) << stride_log2(r);
    mask   = stride - idx_t'(1);
    rem    = (cur - grid_offset(r)) & mask;
    if (rem == '0)
      return ccw ? (cur - stride) : (cur + stride);
    return ccw ? (cur - rem) : (cur + (stride - rem));
  endfunction

  // Magnitude step to ratio code: twice the step, saturating at full scale.
  function automatic code_t step_code(input mag_t k);
    if (k == mag_t'(OCT_N))
      return '1;
    return code_t'({k, 1'b0});
  endfunction
endpackage

// File: rtl/seq_position.sv
module seq_position
  import stepseq_pkg::*;
(
  input  logic step_clk,
  input  logic rst,
  input  logic hold,
  input  logic ccw,
  input  res_e res_in,
  output idx_t pos,
  output res_e res_lat,
  output logic adv
);
  idx_t pos_nxt;

  assign adv     = ~hold;
  assign pos_nxt = next_index(pos, ccw, res_in);

  always_ff @(posedge step_clk or posedge rst) begin
    if (rst) begin
      pos     <= '0;
      res_lat <= RES_EIGHTH;
    end else if (adv) begin
      pos     <= pos_nxt;
      res_lat <= res_in;
    end
  end
endmodule

// File: rtl/diag_detect.sv
module diag_detect
  import stepseq_pkg::*;
(
  input  logic [OCT_W-1:0] oct,
  output logic             on_diag
);
  localparam logic [OCT_W-1:0] DIAG_OCT = OCT_W'(OCT_N / 2);

  assign on_diag = (oct == DIAG_OCT);
endmodule

// File: rtl/phase_driver.sv
module phase_driver
  import stepseq_pkg::*;
#(
  parameter int PHASE = 0   // 0 = phase A (cosine side), 1 = phase B
) (
  input  idx_t  pos,
  input  logic  on_diag,
  input  logic  coarse,
  output logic  pol,
  output code_t code
);
  localparam logic IS_B = (PHASE != 0);

  logic [1:0]       quad;
  logic [OCT_W-1:0] oct;
  mag_t             oct_w;
  mag_t             mag;
  logic             swap;

  assign quad  = pos[IDX_W-1:OCT_W];
  assign oct   = pos[OCT_W-1:0];
  assign oct_w = mag_t'(oct);
  assign swap  = quad[0] ^ IS_B;
  assign mag   = swap ? oct_w : (mag_t'(OCT_N) - oct_w);
  assign code  = (on_diag && coarse) ? '1 : step_code(mag);

  generate
    if (PHASE == 0) begin : g_pol_a
      assign pol = ~(quad[1] ^ quad[0]);
    end else begin : g_pol_b
      assign pol = ~quad[1];
    end
  endgenerate
endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer
  import stepseq_pkg::*;
(
  input  logic              step_clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              dir,
  input  logic [1:0]        res_sel,
  output logic              pol_a,
  output logic              pol_b,
  output logic [CODE_W-1:0] ratio_a,
  output logic [CODE_W-1:0] ratio_b,
  output logic              diag_mon
);
  idx_t  pos_idx;
  res_e  res_lat;
  logic  step_adv;
  logic  on_diag;
  logic  coarse;
  logic  pol_v  [2];
  code_t code_v [2];

  seq_position u_pos (
    .step_clk (step_clk),
    .rst      (rst),
    .hold     (hold),
    .ccw      (dir),
    .res_in   (res_e'(res_sel)),
    .pos      (pos_idx),
    .res_lat  (res_lat),
    .adv      (step_adv)
  );

  diag_detect u_diag (
    .oct     (pos_idx[OCT_W-1:0]),
    .on_diag (on_diag)
  );

  assign coarse = is_coarse(res_lat);

  generate
    for (genvar p = 0; p < 2; p++) begin : g_phase
      phase_driver #(.PHASE(p)) u_ph (
        .pos     (pos_idx),
        .on_diag (on_diag),
        .coarse  (coarse),
        .pol     (pol_v[p]),
        .code    (code_v[p])
      );
    end
  endgenerate

  assign pol_a    = pol_v[0];
  assign pol_b    = pol_v[1];
  assign ratio_a  = code_v[0];
  assign ratio_b  = code_v[1];
  assign diag_mon = on_diag;
endmodule

// File: rtl/ustep_sequencer_chk.sv
module ustep_sequencer_chk
  import stepseq_pkg::*;
(
  input logic              step_clk,
  input logic              rst,
  input logic              hold,
  input logic              dir,
  input logic [1:0]        res_sel,
  input logic              pol_a,
  input logic              pol_b,
  input logic [CODE_W-1:0] ratio_a,
  input logic [CODE_W-1:0] ratio_b,
  input logic              diag_mon,
  input logic [IDX_W-1:0]  pos_idx,
  input logic              step_adv
);
  // R1
  home_chk: assert property (@(posedge step_clk)
    rst |-> (ratio_a == 4'hF && ratio_b == 4'h0 && pol_a && pol_b && !diag_mon));

  // R9
  hold_freeze_chk: assert property (@(posedge step_clk) disable iff (rst)
    hold |=> $stable({pol_a, pol_b, ratio_a, ratio_b, diag_mon}));

  // R10
  mon_match_chk: assert property (@(posedge step_clk) disable iff (rst)
    diag_mon == (ratio_a == ratio_b));

  // R7
  diag_code_chk: assert property (@(posedge step_clk) disable iff (rst)
    diag_mon |-> (ratio_a == 4'h8 || ratio_a == 4'hF));

  // R4
  cw_step_chk: assert property (@(posedge step_clk) disable iff (rst)
    (step_adv && res_sel == 2'b11 && !dir) |=> (pos_idx == $past(pos_idx) + 5'd1));

  // R4
  ccw_step_chk: assert property (@(posedge step_clk) disable iff (rst)
    (step_adv && res_sel == 2'b11 && dir) |=> (pos_idx == $past(pos_idx) - 5'd1));
endmodule

bind ustep_sequencer ustep_sequencer_chk u_chk (
  .step_clk (step_clk),
  .rst      (rst),
  .hold     (hold),
  .dir      (dir),
  .res_sel  (res_sel),
  .pol_a    (pol_a),
  .pol_b    (pol_b),
  .ratio_a  (ratio_a),
  .ratio_b  (ratio_b),
  .diag_mon (diag_mon),
  .pos_idx  (pos_idx),
  .step_adv (step_adv)
);

// File: tb/sim_ustep_sequencer.sv
module sim_ustep_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       hold = 1'b0;
  logic       dir = 1'b0;
  logic [1:0] res_sel = 2'b11;
  logic       pol_a, pol_b, diag_mon;
  logic [3:0] ratio_a, ratio_b;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  int         m_idx = 0;
  logic [1:0] m_res = 2'b11;

  ustep_sequencer u0 (
    .step_clk (clk), .rst (rst), .hold (hold), .dir (dir), .res_sel (res_sel),
    .pol_a (pol_a), .pol_b (pol_b), .ratio_a (ratio_a), .ratio_b (ratio_b),
    .diag_mon (diag_mon)
  );

  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [3:0] exp_code(input int k);
    case (k)
      0: return 4'h0;  1: return 4'h2;  2: return 4'h4;
      3: return 4'h6;  4: return 4'h8;  5: return 4'hA;
      6: return 4'hC;  7: return 4'hE;  default: return 4'hF;
    endcase
  endfunction

  // Walk one position at a time until landing on the grid.
  function automatic int bnext(input int i, input bit d, input logic [1:0] r);
    int s, g, x;
    case (r)
      2'b00:   begin s = 8; g = 4; end
      2'b10:   begin s = 4; g = 0; end
      2'b01:   begin s = 2; g = 0; end
      default: begin s = 1; g = 0; end
    endcase
    x = i;
    if (((x - g + 32) % s) == 0) begin
      x = d ? (x - s + 32) % 32 : (x + s) % 32;
    end else begin
      for (int n = 0; n < 8; n++)
        if (((x - g + 32) % s) != 0) x = d ? (x + 31) % 32 : (x + 1) % 32;
    end
    return x;
  endfunction

  function automatic logic [10:0] expected();
    int q, o, ka;
    logic [3:0] ca, cb;
    logic coarse;
    q  = m_idx / 8;
    o  = m_idx % 8;
    ka = (q % 2 == 0) ? 8 - o : o;
    coarse = (m_res == 2'b00) || (m_res == 2'b10);
    ca = exp_code(ka);
    cb = exp_code(8 - ka);
    if (o == 4 && coarse) begin ca = 4'hF; cb = 4'hF; end
    return {(q == 0 || q == 3), (q < 2), ca, cb, (o == 4)};
  endfunction

  task automatic chk(input string req);
    logic [10:0] act, exp;
    act = {pol_a, pol_b, ratio_a, ratio_b, diag_mon};
    exp = expected();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s idx=%0d actual=%h expected=%h (pa,pb,ra,rb,mon)",
               req, m_idx, act, exp);
    end
  endtask

  // One step period: inputs change at the falling edge, outputs are
  // checked once before the rising edge and once after it.
  task automatic cyc(input bit h, input bit d, input logic [1:0] r,
                     input string tag);
    @(negedge clk);
    hold = h; dir = d; res_sel = r;
    #1 chk("R8");
    if (!h) begin
      m_idx = bnext(m_idx, d, r);
      m_res = r;
    end
    @(posedge clk);
    #2 chk(h ? "R9" : tag);
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst = 1'b1;
    hold = 1'b1;
    #2 chk("R1");
    @(negedge clk); chk("R1");
    @(negedge clk); chk("R1");
    rst = 1'b0;
    // Hold: position frozen across edges
    cyc(1, 0, 2'b11, "R9");
    cyc(1, 1, 2'b00, "R9");
    // Full eighth-step walk clockwise, through the wrap
    for (int i = 0; i < 33; i++) cyc(0, 0, 2'b11, "R2/R3/R10");
    // Counter-clockwise across zero: 1 -> 0 -> 31 -> 30
    for (int i = 0; i < 3; i++) cyc(0, 1, 2'b11, "R4");
    // Off-grid into full step: 30 -> 4, then 4 -> 12
    cyc(0, 0, 2'b00, "R6");
    cyc(0, 0, 2'b00, "R5/R7");
    cyc(0, 1, 2'b00, "R5/R7");
    // Quarter step from diagonal 4 -> 6, then half CCW snaps to 4
    cyc(0, 0, 2'b01, "R5");
    cyc(0, 1, 2'b10, "R6");
    // Eighth step at a diagonal keeps code 8: 4 -> 5 -> 4
    cyc(0, 0, 2'b11, "R7");
    cyc(0, 1, 2'b11, "R7");
    // Half step clockwise from 3 after an eighth step back
    cyc(0, 1, 2'b11, "R4");
    cyc(0, 0, 2'b10, "R6");
    // Asynchronous reset mid-period
    @(negedge clk);
    #1 rst = 1'b1;
    m_idx = 0; m_res = 2'b11;
    #1 chk("R1");
    hold = 1'b1;
    @(negedge clk); chk("R1");
    rst = 1'b0;
    // Random run
    begin
      int seed_dummy;
      logic [1:0] r;
      seed_dummy = $urandom(32'h5eed);
      r = 2'b11;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 9) == 0) r = 2'($urandom_range(0, 3));
        cyc($urandom_range(0, 7) == 0, 1'($urandom_range(0, 1)), r, "R5");
      end
    end
    finish_run();
  end
endmodule